// File: doc/BRIEF.md
# Coarse-Fine Interval Meter

This block measures the time between a start event and a stop event. Neither event is tied to the system clock. Each event line reaches the block as a parallel word of `SLOTS` samples once per word clock. Each bit of the word stands for one equal sub-cycle slot of that clock period, as a tapped delay chain, multi-phase sampling or a deserializer would produce. Bit 0 is the earliest slot.

An event is a falling transition in the sample stream. The block checks every adjacent pair of samples, including the pair formed by the last bit of the previous word and bit 0 of the current word, and finds the slot where the line drops. That fine position is combined with a coarse count of whole words between the start word and the stop word. The result is one unsigned interval code in units of one slot, so the resolution is finer than one clock period.

A one-cycle `result_valid` pulse marks each finished measurement. If no stop arrives before the coarse count saturates, the measurement is closed with an overflow flag.

Top module: `cf_interval_meter`

## Requirements
- R1: The fine position of an event is the slot index p (0 to SLOTS-1) at which the sampled stream first reads 0 after a 1. For p > 0 this is bit p-1 = 1 and bit p = 0 of the word. For p = 0 it is the last bit of the previous word = 1 and bit 0 = 0.
- R2: When a word holds several 1-to-0 pairs (bubbles), the lowest slot index among them is taken.
- R3: While idle, the first word that holds a start transition arms a measurement and becomes word 0 of the coarse count.
- R4: A stop transition in word d (1 ≤ d ≤ 2^CW-1) after the start word produces `interval = d*SLOTS + p_stop - p_start`, with `result_valid` high in the cycle after the edge that samples the stop word and `overflow` low.
- R5: A stop transition is ignored while idle, after a result has been reported, and in the same word as the start.
- R6: Start transitions that appear while a measurement is running are ignored, and the armed start position is kept.
- R7: If word 2^CW-1 passes without a stop, `result_valid` and `overflow` are high together in the cycle after that word, and `interval` reads all ones.
- R8: `result_valid` and `overflow` last exactly one cycle, and `interval` holds its value between results.
- R9: A synchronous active-high reset abandons any measurement, returns the block to idle, clears the outputs to zero and clears the stored last bit of each line to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| start_word | input | SLOTS | Sampled start line, bit 0 earliest slot |
| stop_word | input | SLOTS | Sampled stop line, bit 0 earliest slot |
| interval | output | CW+clog2(SLOTS) | Measured interval in slots |
| result_valid | output | 1 | One-cycle strobe for a finished measurement |
| overflow | output | 1 | Coarse count saturated without a stop |

## Verification
A result is due exactly one clock edge after the edge that samples the stop word. An overflow is due one edge after the word with coarse index 2^CW-1. The bench drives each word on the falling clock edge and reads the outputs shortly after the next falling edge, so each check sees the state produced by the word driven one step earlier. A small configuration (4 slots, 4-bit coarse count) is swept over every start slot, every stop slot and several word distances up to the largest legal one. Each expected code is computed arithmetically. A pulse counter confirms that no stray strobe appears between results.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

   typedef enum logic {
      CFI_IDLE = 1'b0,
      CFI_RUN  = 1'b1
   } cfi_state_e;

   // number of index bits needed for a slot position
   function automatic int unsigned cfi_pos_bits(input int unsigned slots);
      return (slots <= 2) ? 1 : $clog2(slots);
   endfunction

endpackage

// File: rtl/cfi_edge_locate.sv
// Finds the earliest 1-to-0 step in a sampled line, looking across word borders.
module cfi_edge_locate #(
   parameter int SLOTS = 16,
   parameter int FW    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SLOTS-1:0] word,
   output logic             found,
   output logic [FW-1:0]    pos
);

   logic               last_q;
   logic [SLOTS:0]     ext;
   logic [SLOTS-1:0]   fall;

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= word[SLOTS-1];
   end

   // ext[k] is the sample just before slot k
   assign ext = {word, last_q};

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_pair
         assign fall[k] = ext[k] & ~ext[k+1];
      end
   endgenerate

   // lowest slot wins
   always_comb begin
      pos = '0;
      for (int k = SLOTS - 1; k >= 0; k--) begin
         if (fall[k]) pos = FW'(k);
      end
   end

   assign found = |fall;

endmodule

// File: rtl/cfi_coarse_ctrl.sv
// Arms on start, counts whole words, ends on stop or saturation.
module cfi_coarse_ctrl
   import cfi_pkg::*;
#(
   parameter int CW = 8,
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_found,
   input  logic [FW-1:0] start_pos,
   input  logic          stop_found,
   output logic          done,
   output logic          sat,
   output logic [CW-1:0] words,
   output logic [FW-1:0] armed_pos
);

   localparam logic [CW-1:0] LAST_WORD = {CW{1'b1}};

   cfi_state_e    state_q;
   logic [CW-1:0] words_q;
   logic [FW-1:0] pos_q;
   logic          running;

   assign running = (state_q == CFI_RUN);
   assign done    = running && (stop_found || (words_q == LAST_WORD));
   assign sat     = running && !stop_found && (words_q == LAST_WORD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= CFI_IDLE;
         words_q <= '0;
         pos_q   <= '0;
      end else begin
         case (state_q)
            CFI_IDLE: begin
               if (start_found) begin
                  state_q <= CFI_RUN;
                  words_q <= CW'(1);
                  pos_q   <= start_pos;
               end
            end
            CFI_RUN: begin
               if (done) state_q <= CFI_IDLE;
               else      words_q <= words_q + 1'b1;
            end
            default: state_q <= CFI_IDLE;
         endcase
      end
   end

   assign words     = words_q;
   assign armed_pos = pos_q;

endmodule

// File: rtl/cfi_combine.sv
// Joins coarse word count and fine positions into one registered code.
module cfi_combine #(
   parameter int SLOTS = 16,
   parameter int CW    = 8,
   parameter int FW    = 4,
   parameter int OW    = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          done,
   input  logic          sat,
   input  logic [CW-1:0] words,
   input  logic [FW-1:0] start_pos,
   input  logic [FW-1:0] stop_pos,
   output logic [OW-1:0] interval,
   output logic          result_valid,
   output logic          overflow
);

   localparam bit POW2 = ((SLOTS & (SLOTS - 1)) == 0) && (OW == CW + FW);

   logic [OW-1:0] scaled;
   logic [OW-1:0] code;

   generate
      if (POW2) begin : g_concat
         assign scaled = {words, stop_pos};
      end else begin : g_mult
         assign scaled = OW'(words) * OW'(SLOTS) + OW'(stop_pos);
      end
   endgenerate

   assign code = scaled - OW'(start_pos);

   always_ff @(posedge clk) begin
      if (rst) begin
         interval     <= '0;
         result_valid <= 1'b0;
         overflow     <= 1'b0;
      end else begin
         result_valid <= done;
         overflow     <= sat;
         if (done) interval <= sat ? {OW{1'b1}} : code;
      end
   end

endmodule

// File: rtl/cf_interval_meter.sv
module cf_interval_meter #(
   parameter int SLOTS = 16,
   parameter int CW    = 8
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [SLOTS-1:0]                 start_word,
   input  logic [SLOTS-1:0]                 stop_word,
   output logic [CW+cfi_pkg::cfi_pos_bits(SLOTS)-1:0] interval,
   output logic                             result_valid,
   output logic                             overflow
);

   localparam int FW = cfi_pkg::cfi_pos_bits(SLOTS);
   localparam int OW = CW + FW;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("cf_interval_meter: SLOTS must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("cf_interval_meter: CW must be at least 2");
      end
   endgenerate

   logic          start_found, stop_found;
   logic [FW-1:0] start_pos, stop_pos, armed_pos;
   logic          done, sat;
   logic [CW-1:0] words;

   cfi_edge_locate #(.SLOTS(SLOTS), .FW(FW)) u_start_edge (
      .clk   (clk),
      .rst   (rst),
      .word  (start_word),
      .found (start_found),
      .pos   (start_pos)
   );

   cfi_edge_locate #(.SLOTS(SLOTS), .FW(FW)) u_stop_edge (
      .clk   (clk),
      .rst   (rst),
      .word  (stop_word),
      .found (stop_found),
      .pos   (stop_pos)
   );

   cfi_coarse_ctrl #(.CW(CW), .FW(FW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .start_found (start_found),
      .start_pos   (start_pos),
      .stop_found  (stop_found),
      .done        (done),
      .sat         (sat),
      .words       (words),
      .armed_pos   (armed_pos)
   );

   cfi_combine #(.SLOTS(SLOTS), .CW(CW), .FW(FW), .OW(OW)) u_combine (
      .clk          (clk),
      .rst          (rst),
      .done         (done),
      .sat          (sat),
      .words        (words),
      .start_pos    (armed_pos),
      .stop_pos     (stop_pos),
      .interval     (interval),
      .result_valid (result_valid),
      .overflow     (overflow)
   );

endmodule

// File: rtl/cf_interval_meter_chk.sv
module cf_interval_meter_chk #(
   parameter int SLOTS = 16,
   parameter int CW    = 8,
   parameter int OW    = 12
) (
   input logic          clk,
   input logic          rst,
   input logic [OW-1:0] interval,
   input logic          result_valid,
   input logic          overflow
);

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      result_valid |=> !result_valid);

   assert_ovf_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
      overflow |-> result_valid);

   assert_ovf_saturates_R7: assert property (@(posedge clk) disable iff (rst)
      overflow |-> (interval == {OW{1'b1}}));

   assert_interval_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !result_valid |-> $stable(interval));

   assert_nonzero_code_R4: assert property (@(posedge clk) disable iff (rst)
      (result_valid && !overflow) |-> (interval != '0));

endmodule

bind cf_interval_meter cf_interval_meter_chk #(
   .SLOTS (SLOTS),
   .CW    (CW),
   .OW    (CW + cfi_pkg::cfi_pos_bits(SLOTS))
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .interval     (interval),
   .result_valid (result_valid),
   .overflow     (overflow)
);

// File: tb/cf_interval_meter_tb.sv
module cf_interval_meter_tb;

   localparam int S    = 4;
   localparam int CW   = 4;
   localparam int OW   = 6;
   localparam int MAXD = 15;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [S-1:0]  sw  = '1;
   logic [S-1:0]  pw  = '1;
   logic [OW-1:0] interval;
   logic          result_valid;
   logic          overflow;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   cf_interval_meter #(.SLOTS(S), .CW(CW)) u_dut (
      .clk          (clk),
      .rst          (rst),
      .start_word   (sw),
      .stop_word    (pw),
      .interval     (interval),
      .result_valid (result_valid),
      .overflow     (overflow)
   );

   always #5 clk = ~clk;

   always @(negedge clk) if (!rst && result_valid) pulses++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [S-1:0] therm(input int p);
      logic [S-1:0] w = '0;
      for (int i = 0; i < p; i++) w[i] = 1'b1;
      return w;
   endfunction

   // drive one word pair; outputs afterwards reflect the previous word pair
   task automatic step(input logic [S-1:0] a, input logic [S-1:0] b);
      @(negedge clk);
      sw = a;
      pw = b;
      #1;
   endtask

   task automatic measure(input int ps, input int pe, input int d);
      int p0;
      logic [OW-1:0] held;
      step('1, '1);
      step('1, '1);
      p0 = pulses;
      step(therm(ps), '1);
      for (int k = 1; k < d; k++) step('0, '1);
      step('0, therm(pe));
      step('0, '0);
      chk("R4 valid", int'(result_valid), 1);
      chk("R4 R1 interval", int'(interval), d * S + pe - ps);
      chk("R4 overflow low", int'(overflow), 0);
      held = interval;
      step('1, '1);
      chk("R8 valid one cycle", int'(result_valid), 0);
      chk("R8 interval held", int'(interval), int'(held));
      chk("R3 single pulse", pulses - p0, 1);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int p0;
      repeat (3) step('1, '1);
      chk("R9 reset valid", int'(result_valid), 0);
      chk("R9 reset overflow", int'(overflow), 0);
      chk("R9 reset interval", int'(interval), 0);
      rst = 1'b0;

      // R1 R4 sweep over start slot, stop slot and distance
      for (int ps = 0; ps < S; ps++)
         for (int pe = 0; pe < S; pe++) begin
            measure(ps, pe, 1);
            measure(ps, pe, 2);
            measure(ps, pe, 3);
            measure(ps, pe, MAXD);
         end

      // R2 bubbles: start 0101 -> slot 1, stop 1011 -> slot 2
      step('1, '1);
      step('1, '1);
      step(4'b0101, '1);
      step('0, '1);
      step('0, 4'b1011);
      step('0, '0);
      chk("R2 bubble interval", int'(interval), 2 * S + 2 - 1);

      // R6 second start during run is ignored
      step('1, '1);
      step('1, '1);
      step(therm(1), '1);
      step('1, '1);
      step(therm(3), '1);
      step('0, therm(2));
      step('0, '0);
      chk("R6 valid", int'(result_valid), 1);
      chk("R6 interval uses first start", int'(interval), 3 * S + 2 - 1);

      // R7 overflow, then R5 stop after result ignored
      step('1, '1);
      step('1, '1);
      p0 = pulses;
      step(therm(1), '1);
      for (int k = 1; k <= MAXD; k++) step('0, '1);
      step('0, therm(2));
      chk("R7 valid", int'(result_valid), 1);
      chk("R7 overflow", int'(overflow), 1);
      chk("R7 interval saturated", int'(interval), (1 << OW) - 1);
      step('0, '0);
      chk("R5 stop after result ignored", int'(result_valid), 0);
      chk("R7 single pulse before late stop", pulses - p0, 1);

      // R5 stop in the same word as start is ignored -> overflow
      step('1, '1);
      step('1, '1);
      p0 = pulses;
      step(therm(1), therm(3));
      for (int k = 1; k <= MAXD; k++) step('0, '0);
      step('1, '1);
      chk("R5 same-word stop ignored", int'(overflow), 1);
      chk("R5 no early result", pulses - p0, 1);

      // R5 stop while idle is ignored
      p0 = pulses;
      step('1, '1);
      step('1, therm(2));
      step('1, '0);
      step('1, '0);
      chk("R5 idle stop ignored", pulses - p0, 0);

      // R9 reset mid-measurement abandons it
      step('1, '1);
      step(therm(0), '1);
      step('0, '1);
      rst = 1'b1;
      step('0, '1);
      step('0, '1);
      chk("R9 reset clears valid", int'(result_valid), 0);
      chk("R9 reset clears interval", int'(interval), 0);
      rst = 1'b0;
      p0 = pulses;
      step('0, therm(1));
      step('0, '0);
      step('0, '0);
      chk("R9 no result after reset", pulses - p0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule